// File: doc/BRIEF.md
# Cluster Coherence Bridge Filter

This block sits at the boundary between one cluster's local coherence bus and the global bus that joins clusters. It watches every transaction on both buses and decides whether the transaction has to cross the boundary. A transaction that stays inside its own bus costs no global bandwidth. A transaction that must cross is placed in a single forward slot. The slot drives a forward strobe toward the other bus and holds it until that bus accepts it.

The decision combines three pieces of information. The first is the line's home cluster, decoded from the upper address bits. The second is a tag-only table of remotely homed lines that the cluster holds, each with a dirty flag. The third is a tag-only table of locally homed lines that caches outside the cluster hold, also with a dirty flag. Both tables are direct-mapped and store no data. They are updated when a forward completes, or at once for global transactions that need no forward.

Either bus may offer one transaction per cycle with a valid strobe. The bus sees a busy flag while the block cannot take that transaction. A transaction is accepted in a cycle where valid is high and busy is low.

Top module: `cbf_bridge_filter`

## Requirements
- R1: After reset both tables are empty, both forward strobes are low and both busy flags are low.
- R2: An accepted local write to a line whose home cluster field differs from CLUSTER_ID is forwarded up (up_valid, up_write=1, up_addr equal to the local address) in the cycle after acceptance.
- R3: An accepted local write to a locally homed line is forwarded up only if the outside-holder table has a matching entry for it.
- R4: An accepted local read of a remotely homed line is forwarded up only if the inside-holder table has no matching entry. Completing that forward records the line as held clean.
- R5: An accepted local read of a locally homed line is forwarded up only if its outside-holder entry is marked dirty. Completing that forward clears the dirty mark and keeps the entry.
- R6: An accepted global write to a locally homed line is passed down (dn_valid, dn_write=1, dn_addr equal to the global address). Completing it records the line as held dirty outside the cluster.
- R7: An accepted global write to a remotely homed line is passed down only if the inside-holder entry is dirty, and completing it removes the entry. A clean matching entry is removed at acceptance, with no forward.
- R8: A global read is never passed down. A global read of a locally homed line with no matching entry creates a clean outside-holder entry.
- R9: Completing a forwarded local write marks a remotely homed line dirty in the inside-holder table. For a locally homed line it removes the outside-holder entry.
- R10: At most one forward is outstanding. While it is outstanding, both busy flags are high and the forward's strobe, address and kind stay constant until the receiving bus's ready is high.
- R11: With the default GLOBAL_FIRST=1, a global transaction that needs a forward takes precedence when it arrives in the same cycle as a local one. In that cycle lb_busy is high and gb_busy is low.
- R12: The home cluster is the top CW address bits. The table index is the IDX_W bits just above the OFF_W offset bits, and the tag is the top AW-IDX_W-OFF_W bits.
- R13: Each table has one entry per index. Recording a line whose index holds a different tag overwrites that entry, so the earlier line no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lb_valid | input | 1 | Local bus transaction offered |
| lb_write | input | 1 | Local transaction is a write (0 = read) |
| lb_addr | input | AW | Local transaction address |
| lb_busy | output | 1 | Local transaction cannot be taken this cycle |
| gb_valid | input | 1 | Global bus transaction offered |
| gb_write | input | 1 | Global transaction is a write (0 = read) |
| gb_addr | input | AW | Global transaction address |
| gb_busy | output | 1 | Global transaction cannot be taken this cycle |
| up_valid | output | 1 | Forward toward the global bus pending |
| up_write | output | 1 | Kind of the upward forward |
| up_addr | output | AW | Address of the upward forward |
| up_ready | input | 1 | Global bus accepts the upward forward |
| dn_valid | output | 1 | Forward toward the local bus pending |
| dn_write | output | 1 | Kind of the downward forward |
| dn_addr | output | AW | Address of the downward forward |
| dn_ready | input | 1 | Local bus accepts the downward forward |

## Verification
The busy flags depend on the current inputs within the same cycle. The bench therefore reads them one time step after it drives a transaction, before the accepting edge. A forward decision is registered, so the strobe is due exactly one edge after acceptance. The bench samples it at the falling edge that follows, then holds ready low for zero to two cycles to confirm the forward stays put. Table updates land on the completing edge, or on the accepting edge for global transactions that are not forwarded. The bench's own table model is updated at that point, so the next transaction's expected decision reflects it.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
   // Update applied to one tag-only table entry.
   typedef enum logic [2:0] {
      TBL_NOP,
      TBL_FILL_CLEAN,   // install tag, not dirty
      TBL_FILL_DIRTY,   // install tag, dirty
      TBL_DROP,         // invalidate if tag matches
      TBL_CLEAN,        // clear dirty if tag matches
      TBL_SHARE         // install clean only if tag misses
   } tbl_op_e;
endpackage

// File: rtl/cbf_home_decode.sv
module cbf_home_decode #(
   parameter int CW         = 2,
   parameter int CLUSTER_ID = 1
) (
   input  logic [CW-1:0] home_bits,
   output logic          is_local
);
   localparam logic [CW-1:0] MY_ID = CW'(CLUSTER_ID);
   assign is_local = (home_bits == MY_ID);
endmodule

// File: rtl/cbf_tag_table.sv
module cbf_tag_table
   import cbf_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] qa_idx,
   input  logic [TAG_W-1:0] qa_tag,
   output logic             qa_hit,
   output logic             qa_dirty,
   input  logic [IDX_W-1:0] qb_idx,
   input  logic [TAG_W-1:0] qb_tag,
   output logic             qb_hit,
   output logic             qb_dirty,
   input  logic             upd_en,
   input  tbl_op_e          upd_op,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0] upd_tag
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0]            ent_v;
   logic [DEPTH-1:0]            ent_d;
   logic [DEPTH-1:0][TAG_W-1:0] ent_tag;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic             v_q;
      logic             d_q;
      logic [TAG_W-1:0] t_q;
      logic             sel;
      logic             match;

      assign sel   = upd_en && (upd_idx == IDX_W'(e));
      assign match = v_q && (t_q == upd_tag);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
         end else if (sel) begin
            case (upd_op)
               TBL_FILL_CLEAN: begin v_q <= 1'b1; d_q <= 1'b0; t_q <= upd_tag; end
               TBL_FILL_DIRTY: begin v_q <= 1'b1; d_q <= 1'b1; t_q <= upd_tag; end
               TBL_DROP:       if (match) begin v_q <= 1'b0; d_q <= 1'b0; end
               TBL_CLEAN:      if (match) d_q <= 1'b0;
               TBL_SHARE:      if (!match) begin v_q <= 1'b1; d_q <= 1'b0; t_q <= upd_tag; end
               default: ;
            endcase
         end
      end

      assign ent_v[e]   = v_q;
      assign ent_d[e]   = d_q;
      assign ent_tag[e] = t_q;
   end

   assign qa_hit   = ent_v[qa_idx] && (ent_tag[qa_idx] == qa_tag);
   assign qa_dirty = qa_hit && ent_d[qa_idx];
   assign qb_hit   = ent_v[qb_idx] && (ent_tag[qb_idx] == qb_tag);
   assign qb_dirty = qb_hit && ent_d[qb_idx];
endmodule

// File: rtl/cbf_fwd_slot.sv
module cbf_fwd_slot
   import cbf_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_up,
   input  logic          load_write,
   input  logic [AW-1:0] load_addr,
   input  logic          load_sel_lht,
   input  tbl_op_e       load_op,
   input  logic          up_ready,
   input  logic          dn_ready,
   output logic          up_valid,
   output logic          dn_valid,
   output logic          fwd_write,
   output logic [AW-1:0] fwd_addr,
   output logic          full,
   output logic          done,
   output logic          done_sel_lht,
   output tbl_op_e       done_op
);
   logic          full_q, up_q, wr_q, lht_q;
   logic [AW-1:0] addr_q;
   tbl_op_e       op_q;

   assign done = full_q && (up_q ? up_ready : dn_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         up_q   <= 1'b0;
         wr_q   <= 1'b0;
         lht_q  <= 1'b0;
         addr_q <= '0;
         op_q   <= TBL_NOP;
      end else begin
         if (done) full_q <= 1'b0;
         if (load) begin
            full_q <= 1'b1;
            up_q   <= load_up;
            wr_q   <= load_write;
            lht_q  <= load_sel_lht;
            addr_q <= load_addr;
            op_q   <= load_op;
         end
      end
   end

   assign up_valid     = full_q && up_q;
   assign dn_valid     = full_q && !up_q;
   assign fwd_write    = wr_q;
   assign fwd_addr     = addr_q;
   assign full         = full_q;
   assign done_sel_lht = lht_q;
   assign done_op      = op_q;
endmodule

// File: rtl/cbf_bridge_filter.sv
module cbf_bridge_filter
   import cbf_pkg::*;
#(
   parameter int AW           = 12,
   parameter int CW           = 2,
   parameter int CLUSTER_ID   = 1,
   parameter int IDX_W        = 2,
   parameter int OFF_W        = 2,
   parameter bit GLOBAL_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lb_valid,
   input  logic          lb_write,
   input  logic [AW-1:0] lb_addr,
   output logic          lb_busy,
   input  logic          gb_valid,
   input  logic          gb_write,
   input  logic [AW-1:0] gb_addr,
   output logic          gb_busy,
   output logic          up_valid,
   output logic          up_write,
   output logic [AW-1:0] up_addr,
   input  logic          up_ready,
   output logic          dn_valid,
   output logic          dn_write,
   output logic [AW-1:0] dn_addr,
   input  logic          dn_ready
);
   localparam int TAG_W = AW - IDX_W - OFF_W;

   if (CW + IDX_W + OFF_W > AW) begin : g_bad_width
      $error("cbf_bridge_filter: home, index and offset fields exceed the address");
   end
   if (CLUSTER_ID >= (1 << CW) || CLUSTER_ID < 0) begin : g_bad_id
      $error("cbf_bridge_filter: CLUSTER_ID does not fit in CW bits");
   end

   // address fields
   logic [IDX_W-1:0] lb_idx, gb_idx, dn_idx_u;
   logic [TAG_W-1:0] lb_tag, gb_tag, dn_tag_u;
   assign lb_idx = lb_addr[OFF_W +: IDX_W];
   assign lb_tag = lb_addr[AW-1 -: TAG_W];
   assign gb_idx = gb_addr[OFF_W +: IDX_W];
   assign gb_tag = gb_addr[AW-1 -: TAG_W];

   // home decode
   logic lb_loc, gb_loc;
   cbf_home_decode #(.CW(CW), .CLUSTER_ID(CLUSTER_ID)) u_lb_home (
      .home_bits(lb_addr[AW-1 -: CW]), .is_local(lb_loc));
   cbf_home_decode #(.CW(CW), .CLUSTER_ID(CLUSTER_ID)) u_gb_home (
      .home_bits(gb_addr[AW-1 -: CW]), .is_local(gb_loc));

   // tables: port a looks up the local bus, port b the global bus
   logic    rht_a_hit, rht_a_dirty, rht_b_hit, rht_b_dirty;
   logic    lht_a_hit, lht_a_dirty, lht_b_hit, lht_b_dirty;
   logic    rht_en, lht_en;
   tbl_op_e rht_op, lht_op;
   logic [IDX_W-1:0] rht_uidx, lht_uidx;
   logic [TAG_W-1:0] rht_utag, lht_utag;

   cbf_tag_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_inside_tbl (
      .clk(clk), .rst_n(rst_n),
      .qa_idx(lb_idx), .qa_tag(lb_tag), .qa_hit(rht_a_hit), .qa_dirty(rht_a_dirty),
      .qb_idx(gb_idx), .qb_tag(gb_tag), .qb_hit(rht_b_hit), .qb_dirty(rht_b_dirty),
      .upd_en(rht_en), .upd_op(rht_op), .upd_idx(rht_uidx), .upd_tag(rht_utag));

   cbf_tag_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_outside_tbl (
      .clk(clk), .rst_n(rst_n),
      .qa_idx(lb_idx), .qa_tag(lb_tag), .qa_hit(lht_a_hit), .qa_dirty(lht_a_dirty),
      .qb_idx(gb_idx), .qb_tag(gb_tag), .qb_hit(lht_b_hit), .qb_dirty(lht_b_dirty),
      .upd_en(lht_en), .upd_op(lht_op), .upd_idx(lht_uidx), .upd_tag(lht_utag));

   // forwarding policy
   logic lb_fwd, gb_fwd;
   always_comb begin
      if (lb_write) lb_fwd = !lb_loc || lht_a_hit;
      else if (lb_loc) lb_fwd = lht_a_dirty;
      else lb_fwd = !rht_a_hit;
   end
   assign gb_fwd = gb_write && (gb_loc || rht_b_dirty);

   // completion updates recorded with the forward
   tbl_op_e lb_op, gb_op;
   always_comb begin
      if (lb_write) lb_op = lb_loc ? TBL_DROP  : TBL_FILL_DIRTY;
      else          lb_op = lb_loc ? TBL_CLEAN : TBL_FILL_CLEAN;
   end
   assign gb_op = gb_loc ? TBL_FILL_DIRTY : TBL_DROP;

   // arbitration
   logic slot_full, lb_block, gb_block, lb_take, gb_take;
   if (GLOBAL_FIRST) begin : g_prio_global
      assign gb_block = 1'b0;
      assign lb_block = gb_valid && gb_fwd;
   end else begin : g_prio_local
      assign lb_block = 1'b0;
      assign gb_block = lb_valid && lb_fwd;
   end
   assign lb_busy = slot_full || lb_block;
   assign gb_busy = slot_full || gb_block;
   assign lb_take = lb_valid && !lb_busy;
   assign gb_take = gb_valid && !gb_busy;

   logic load_gb, load_lb;
   assign load_gb = gb_take && gb_fwd;
   assign load_lb = lb_take && lb_fwd;

   logic          slot_done, done_lht, fwd_write;
   logic [AW-1:0] fwd_addr;
   tbl_op_e       done_op;

   cbf_fwd_slot #(.AW(AW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(load_gb || load_lb),
      .load_up(!load_gb),
      .load_write(load_gb ? gb_write : lb_write),
      .load_addr(load_gb ? gb_addr : lb_addr),
      .load_sel_lht(load_gb ? gb_loc : lb_loc),
      .load_op(load_gb ? gb_op : lb_op),
      .up_ready(up_ready), .dn_ready(dn_ready),
      .up_valid(up_valid), .dn_valid(dn_valid),
      .fwd_write(fwd_write), .fwd_addr(fwd_addr),
      .full(slot_full), .done(slot_done),
      .done_sel_lht(done_lht), .done_op(done_op));

   assign up_write = fwd_write;
   assign up_addr  = fwd_addr;
   assign dn_write = fwd_write;
   assign dn_addr  = fwd_addr;

   // immediate updates from global transactions that stay on their bus
   logic gb_keep, rht_imm, lht_imm;
   assign gb_keep = gb_take && !gb_fwd;
   assign rht_imm = gb_keep && gb_write && !gb_loc;
   assign lht_imm = gb_keep && !gb_write && gb_loc;

   assign dn_idx_u = fwd_addr[OFF_W +: IDX_W];
   assign dn_tag_u = fwd_addr[AW-1 -: TAG_W];

   assign rht_en   = (slot_done && !done_lht) || rht_imm;
   assign rht_op   = slot_done ? done_op : TBL_DROP;
   assign rht_uidx = slot_done ? dn_idx_u : gb_idx;
   assign rht_utag = slot_done ? dn_tag_u : gb_tag;

   assign lht_en   = (slot_done && done_lht) || lht_imm;
   assign lht_op   = slot_done ? done_op : TBL_SHARE;
   assign lht_uidx = slot_done ? dn_idx_u : gb_idx;
   assign lht_utag = slot_done ? dn_tag_u : gb_tag;
endmodule

// File: rtl/cbf_bridge_filter_chk.sv
module cbf_bridge_filter_chk #(
   parameter int AW           = 12,
   parameter int CW           = 2,
   parameter int CLUSTER_ID   = 1,
   parameter bit GLOBAL_FIRST = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lb_valid,
   input logic          lb_write,
   input logic [AW-1:0] lb_addr,
   input logic          lb_busy,
   input logic          gb_valid,
   input logic          gb_write,
   input logic [AW-1:0] gb_addr,
   input logic          gb_busy,
   input logic          up_valid,
   input logic          up_write,
   input logic [AW-1:0] up_addr,
   input logic          up_ready,
   input logic          dn_valid,
   input logic          dn_write,
   input logic [AW-1:0] dn_addr,
   input logic          dn_ready
);
   localparam logic [CW-1:0] MY_ID = CW'(CLUSTER_ID);

   a_r10_one_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_valid && dn_valid));

   a_r10_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_ready) |=> (up_valid && $stable(up_addr) && $stable(up_write)));

   a_r10_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr)));

   a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid || dn_valid) |-> (lb_busy && gb_busy));

   a_r8_down_is_write: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_write);

   a_r2_remote_write_up: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_valid && !lb_busy && lb_write && lb_addr[AW-1 -: CW] != MY_ID)
      |=> (up_valid && up_write && up_addr == $past(lb_addr)));

   a_r6_local_write_down: assert property (@(posedge clk) disable iff (!rst_n)
      (gb_valid && !gb_busy && gb_write && gb_addr[AW-1 -: CW] == MY_ID)
      |=> (dn_valid && dn_addr == $past(gb_addr)));

   if (GLOBAL_FIRST) begin : g_prio
      a_r11_global_first: assert property (@(posedge clk) disable iff (!rst_n)
         (gb_valid && !gb_busy && gb_write && gb_addr[AW-1 -: CW] == MY_ID) |-> lb_busy);
   end
endmodule

bind cbf_bridge_filter cbf_bridge_filter_chk #(
   .AW(AW), .CW(CW), .CLUSTER_ID(CLUSTER_ID), .GLOBAL_FIRST(GLOBAL_FIRST)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr), .lb_busy(lb_busy),
   .gb_valid(gb_valid), .gb_write(gb_write), .gb_addr(gb_addr), .gb_busy(gb_busy),
   .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr), .up_ready(up_ready),
   .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_ready(dn_ready)
);

// File: tb/tb_cbf_bridge_filter.sv
module tb_cbf_bridge_filter;
   localparam int AW = 12, CW = 2, CID = 1, IDX_W = 2, OFF_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lb_valid = 1'b0, lb_write = 1'b0, gb_valid = 1'b0, gb_write = 1'b0;
   logic [AW-1:0] lb_addr = '0, gb_addr = '0;
   logic up_ready = 1'b0, dn_ready = 1'b0;
   logic lb_busy, gb_busy, up_valid, up_write, dn_valid, dn_write;
   logic [AW-1:0] up_addr, dn_addr;

   always #5 clk = ~clk;

   cbf_bridge_filter #(.AW(AW), .CW(CW), .CLUSTER_ID(CID), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .lb_valid(lb_valid), .lb_write(lb_write), .lb_addr(lb_addr), .lb_busy(lb_busy),
      .gb_valid(gb_valid), .gb_write(gb_write), .gb_addr(gb_addr), .gb_busy(gb_busy),
      .up_valid(up_valid), .up_write(up_write), .up_addr(up_addr), .up_ready(up_ready),
      .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_ready(dn_ready));

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // bench table model: index = addr[3:2], tag = addr[11:4], home = addr[11:10]
   bit       iv[4], id[4], ov[4], od[4];
   bit [7:0] it[4], ot[4];

   function automatic bit is_loc(logic [AW-1:0] a);
      return a[11:10] == 2'(CID);
   endfunction
   function automatic bit in_hit(logic [AW-1:0] a);
      return iv[a[3:2]] && it[a[3:2]] == a[11:4];
   endfunction
   function automatic bit out_hit(logic [AW-1:0] a);
      return ov[a[3:2]] && ot[a[3:2]] == a[11:4];
   endfunction

   function automatic bit exp_fwd(bit g, bit w, logic [AW-1:0] a);
      if (!g) begin
         if (w) return !is_loc(a) || out_hit(a);
         if (is_loc(a)) return out_hit(a) && od[a[3:2]];
         return !in_hit(a);
      end
      return w && (is_loc(a) || (in_hit(a) && id[a[3:2]]));
   endfunction

   function automatic string req_of(bit g, bit w, logic [AW-1:0] a);
      if (!g) begin
         if (w) return is_loc(a) ? "R3" : "R2";
         return is_loc(a) ? "R5" : "R4";
      end
      if (!w) return "R8";
      return is_loc(a) ? "R6" : "R7";
   endfunction

   task automatic model_upd(bit g, bit w, logic [AW-1:0] a, bit f);
      int i = int'(a[3:2]);
      if (!g && f) begin
         if (w && is_loc(a)) begin if (out_hit(a)) begin ov[i] = 0; od[i] = 0; end end
         else if (w) begin iv[i] = 1; id[i] = 1; it[i] = a[11:4]; end
         else if (is_loc(a)) begin if (out_hit(a)) od[i] = 0; end
         else begin iv[i] = 1; id[i] = 0; it[i] = a[11:4]; end
      end else if (g && f) begin
         if (is_loc(a)) begin ov[i] = 1; od[i] = 1; ot[i] = a[11:4]; end
         else if (in_hit(a)) begin iv[i] = 0; id[i] = 0; end
      end else if (g) begin
         if (!w && is_loc(a) && !out_hit(a)) begin ov[i] = 1; od[i] = 0; ot[i] = a[11:4]; end
         if (w && !is_loc(a) && in_hit(a)) begin iv[i] = 0; id[i] = 0; end
      end
   endtask

   function automatic logic [AW-1:0] mk(int home, int t, int idx);
      return {2'(home), 5'd0, 1'(t), 2'(idx), 2'b01};
   endfunction

   // one transaction on one bus, with dly cycles of ready held low
   task automatic run_txn(bit g, bit w, logic [AW-1:0] a, int dly, string req);
      bit e = exp_fwd(g, w, a);
      @(negedge clk);
      if (g) begin gb_valid = 1; gb_write = w; gb_addr = a; end
      else   begin lb_valid = 1; lb_write = w; lb_addr = a; end
      #1 check("R10", "busy before accept", g ? gb_busy : lb_busy, 0);
      @(negedge clk);
      gb_valid = 0; lb_valid = 0;
      check(req, "forward decision", g ? dn_valid : up_valid, e);
      check("R10", "opposite strobe", g ? up_valid : dn_valid, 0);
      if (e) begin
         check(req, "forward addr", g ? dn_addr : up_addr, a);
         check(req, "forward kind", g ? dn_write : up_write, w);
         check("R10", "busy while pending", lb_busy && gb_busy, 1);
         for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            check("R10", "held until ready", g ? dn_valid : up_valid, 1);
            check("R10", "addr stable", g ? dn_addr : up_addr, a);
         end
         if (g) dn_ready = 1; else up_ready = 1;
         @(negedge clk);
         dn_ready = 0; up_ready = 0;
         check("R10", "slot freed", up_valid || dn_valid || lb_busy || gb_busy, 0);
      end
      model_upd(g, w, a, e);
   endtask

   initial begin
      logic [15:0] lf = 16'hACE1;
      repeat (3) @(negedge clk);
      check("R1", "strobes in reset", up_valid || dn_valid, 0);
      rst_n = 1;
      @(negedge clk);
      check("R1", "idle after reset", up_valid || dn_valid || lb_busy || gb_busy, 0);

      // R1, R3, R12: empty tables, home field decoding
      run_txn(0, 1, mk(1, 0, 0), 0, "R3");
      run_txn(0, 1, mk(0, 0, 0), 1, "R12");
      run_txn(0, 0, mk(2, 0, 1), 0, "R4");
      run_txn(0, 0, mk(2, 0, 1), 0, "R4");
      // R13: same index, other tag evicts
      run_txn(0, 0, mk(2, 1, 1), 0, "R13");
      run_txn(0, 0, mk(2, 0, 1), 2, "R13");
      // R9 then R7: dirty inside copy makes global write go down, then dropped
      run_txn(0, 1, mk(2, 0, 1), 0, "R2");
      run_txn(1, 1, mk(2, 0, 1), 1, "R9");
      run_txn(1, 1, mk(2, 0, 1), 0, "R7");
      // R7: clean inside copy dropped without forward
      run_txn(0, 0, mk(3, 0, 2), 0, "R4");
      run_txn(1, 1, mk(3, 0, 2), 0, "R7");
      run_txn(0, 0, mk(3, 0, 2), 0, "R7");
      // R8, R3, R9: outside sharer forces one write, then cleared
      run_txn(1, 0, mk(1, 0, 3), 0, "R8");
      run_txn(0, 1, mk(1, 0, 3), 0, "R3");
      run_txn(0, 1, mk(1, 0, 3), 0, "R9");
      // R6, R5
      run_txn(1, 1, mk(1, 0, 3), 0, "R6");
      run_txn(0, 0, mk(1, 0, 3), 1, "R5");
      run_txn(0, 0, mk(1, 0, 3), 0, "R5");

      // R11: simultaneous offers, global wins
      @(negedge clk);
      lb_valid = 1; lb_write = 1; lb_addr = mk(2, 1, 0);
      gb_valid = 1; gb_write = 1; gb_addr = mk(1, 1, 2);
      #1 check("R11", "local stalled", lb_busy, 1);
      check("R11", "global free", gb_busy, 0);
      @(negedge clk);
      gb_valid = 0;
      check("R11", "global forwarded first", dn_valid, 1);
      check("R11", "global addr", dn_addr, mk(1, 1, 2));
      check("R11", "no upward yet", up_valid, 0);
      dn_ready = 1;
      @(negedge clk);
      dn_ready = 0;
      model_upd(1, 1, mk(1, 1, 2), 1);
      #1 check("R11", "local now free", lb_busy, 0);
      @(negedge clk);
      lb_valid = 0;
      check("R11", "local forwarded second", up_valid, 1);
      check("R11", "local addr", up_addr, mk(2, 1, 0));
      up_ready = 1;
      @(negedge clk);
      up_ready = 0;
      model_upd(0, 1, mk(2, 1, 0), 1);

      // near-exhaustive sweep over a small address set
      for (int n = 0; n < 400; n++) begin
         bit g, w;
         int home, t, idx, dly;
         logic [AW-1:0] a;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         g = lf[0]; w = lf[1];
         home = (int'(lf[3:2]) == 0) ? 1 : int'(lf[3:2]);
         if (lf[9]) home = CID;
         t = int'(lf[4]); idx = int'(lf[6:5]); dly = int'(lf[8:7]) % 3;
         a = mk(home, t, idx);
         run_txn(g, w, a, dly, req_of(g, w, a));
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end
endmodule